// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial-peripheral slave that gives an external master read and write access to a bank of sixteen 11-bit registers. Each transfer is one 16-bit word sent most significant bit first while the active-low select is held low. The top bit of the word chooses between read and write. The next four bits pick a register, and the low eleven bits carry write data. In the same transfer, the block returns the selected register's current contents on its serial output. These bits start right after the five command bits.

The select, serial clock and serial input pins are brought into a single system clock domain through two-flop synchronisers. All edges are found there. The system clock must run at least four times faster than the serial clock. A write takes effect only when the select rises, and only if the transfer was well formed. A well-formed transfer has exactly sixteen serial clocks, and the serial clock is low both when the select falls and when it rises. A malformed transfer sets a sticky error flag. That flag sits in a read-only status register at address 0. The contents of registers 1 to 15 are also driven onto a flat port for the surrounding logic. The serial output comes with a separate enable, so a pad buffer can float the pin while the port is idle.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, every register reads as zero, `cfg_o` is all zero, the status error bit (address 0, bit 0) is clear, and `miso_oe_o` is low.
- R2: `miso_oe_o` goes high once the select is low, and goes low again once the select is high.
- R3: In every transfer, bits 10:0 of the returned word hold the selected register's value. They are sent most significant bit first, one bit per rising serial clock edge, starting with the sixth rising edge. The master samples each bit before the next falling edge.
- R4: A transfer with bit 15 equal to 0 is a write. If it is well formed and addresses registers 1 to 15, the select release stores bits 10:0 into the register at bits 14:11.
- R5: In a write transfer, the returned bits are the register's value from before the write.
- R6: A transfer with bit 15 equal to 1 is a read and never changes any register.
- R7: A transfer with fewer or more than 16 falling serial clock edges writes nothing and sets the status error bit.
- R8: A transfer where the serial clock is high when the select falls, or high when the select rises, writes nothing and sets the status error bit.
- R9: Address 0 is a status register whose bit 0 is the sticky error flag and whose other bits read as zero. Writes to it are ignored. A well-formed read of address 0 returns the flag and then clears it.
- R10: While the select is high, activity on the serial clock and serial input changes no register and sets no error.
- R11: `cfg_o` carries register k (k = 1..15) at bits [(k-1)*11 +: 11].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| cfg_o | output | 165 | Contents of registers 1..15, 11 bits each |

## Verification
The assertions assume that the three serial inputs come from a master that is slow compared with the system clock. Each serial clock level must last several system clocks, so every edge is seen as a distinct synchronised transition. The select must also stay high long enough between transfers for a commit to finish before the next transfer starts. The bench holds every serial clock phase for eight system clocks and keeps the select high for sixty system clocks between transfers. It changes the serial input only while the serial clock is low. Malformed transfers come only from wrong clock counts or from a clock level that is high at a select edge, never from glitches.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int WORD_W      = 16;
    localparam int DATA_W      = 11;
    localparam int ADDR_W      = 4;
    localparam int NUM_REGS    = 1 << ADDR_W;
    localparam int CMD_BITS    = WORD_W - DATA_W;
    localparam int CNT_W       = $clog2(WORD_W) + 1;
    localparam int STATUS_ADDR = 0;

    // Command word as received, MSB first
    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    // Frame well-formedness checks collected at select release
    typedef struct packed {
        logic start_low;
        logic end_low;
        logic count_ok;
    } frame_chk_t;

    function automatic logic frame_good(input frame_chk_t c);
        return c.start_low & c.end_low & c.count_ok;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spi_regs_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int SADR = STATUS_ADDR
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic                   err_set,
    input  logic                   stat_clr,
    output logic [(NREG-1)*DW-1:0] cfg_o
);
    logic [NREG-1:0][DW-1:0] words;
    logic [NREG-2:0][DW-1:0] cfg_words;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        if (g == SADR) begin : g_status
            always_ff @(posedge clk) begin
                if (rst)           q <= '0;
                else if (err_set)  q <= DW'(1);
                else if (stat_clr) q <= '0;
            end
        end else begin : g_cfg
            always_ff @(posedge clk) begin
                if (rst)                                    q <= '0;
                else if (wr_en && wr_addr == AW'(g))        q <= wr_data;
            end
        end
        assign words[g] = q;
    end

    for (genvar k = 0; k < NREG - 1; k++) begin : g_out
        assign cfg_words[k] = words[(k < SADR) ? k : k + 1];
    end

    assign rd_data = words[rd_addr];
    assign cfg_o   = cfg_words;

    // R6: with no write, error or clear request, the bank holds
    a_r6_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !err_set && !stat_clr) |=> $stable(words));

    // R9: only bit 0 of the status word can ever be set
    a_r9_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (words[SADR][DW-1:1] == '0));

    // R9: flag stays set until a clear request
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (words[SADR][0] && !stat_clr) |=> words[SADR][0]);
endmodule

// File: rtl/spi_frame.sv
module spi_frame
    import spi_regs_pkg::*;
#(
    parameter int WW   = WORD_W,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int CW   = CNT_W,
    parameter int SADR = STATUS_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csn_s,
    input  logic          sck_s,
    input  logic          mosi_s,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          err_set,
    output logic          stat_clr,
    output logic          miso,
    output logic          miso_oe
);
    localparam int CMDB = WW - DW;

    logic          csn_d, sck_d;
    logic          active, start_low, loaded;
    logic [CW-1:0] cnt;
    logic [WW-1:0] sh_in;
    logic [DW-1:0] out_sh;
    logic          miso_q, oe_q;
    logic          wr_q, err_q, clr_q;
    cmd_t          cmd;
    frame_chk_t    chk;

    logic csn_fall, csn_rise, sck_rise, sck_fall;

    assign csn_fall = csn_d & ~csn_s;
    assign csn_rise = ~csn_d & csn_s;
    assign sck_rise = active & ~csn_s & ~sck_d & sck_s;
    assign sck_fall = active & ~csn_s & sck_d & ~sck_s;

    // Address bits complete on the fifth falling edge: three held plus the incoming bit
    assign rd_addr = {sh_in[AW-2:0], mosi_s};

    assign cmd = cmd_t'(sh_in);
    assign chk = '{start_low: start_low, end_low: ~sck_s, count_ok: (cnt == CW'(WW))};

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            csn_d <= csn_s;
            sck_d <= sck_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            start_low <= 1'b0;
            loaded    <= 1'b0;
            cnt       <= '0;
            sh_in     <= '0;
            out_sh    <= '0;
            miso_q    <= 1'b0;
            oe_q      <= 1'b0;
        end else if (csn_fall) begin
            active    <= 1'b1;
            start_low <= ~sck_s;
            loaded    <= 1'b0;
            cnt       <= '0;
            sh_in     <= '0;
            miso_q    <= 1'b0;
            oe_q      <= 1'b1;
        end else if (csn_rise) begin
            active    <= 1'b0;
            oe_q      <= 1'b0;
            loaded    <= 1'b0;
            miso_q    <= 1'b0;
        end else if (sck_fall) begin
            sh_in <= {sh_in[WW-2:0], mosi_s};
            cnt   <= sat_inc(cnt);
            if (cnt == CW'(CMDB - 1)) begin
                out_sh <= rd_data;
                loaded <= 1'b1;
            end
        end else if (sck_rise) begin
            if (loaded) begin
                miso_q <= out_sh[DW-1];
                out_sh <= {out_sh[DW-2:0], 1'b0};
            end else begin
                miso_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b0;
            err_q <= 1'b0;
            clr_q <= 1'b0;
        end else if (csn_rise && active) begin
            wr_q  <= frame_good(chk) & ~cmd.rd;
            err_q <= ~frame_good(chk);
            clr_q <= frame_good(chk) & cmd.rd & (cmd.addr == AW'(SADR));
        end else begin
            wr_q  <= 1'b0;
            err_q <= 1'b0;
            clr_q <= 1'b0;
        end
    end

    assign wr_en    = wr_q;
    assign wr_addr  = cmd.addr;
    assign wr_data  = cmd.data;
    assign err_set  = err_q;
    assign stat_clr = clr_q;
    assign miso     = miso_q;
    assign miso_oe  = oe_q;

    // R7: a commit only follows a frame with exactly the full clock count
    a_r7_commit_count: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(cnt) == CW'(WW)));

    // R8: a commit only follows a frame that started with the clock low
    a_r8_commit_start_low: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(start_low));

    // R2: output enable drops the cycle after select release is seen
    a_r2_oe_off: assert property (@(posedge clk) disable iff (rst)
        (csn_s && !csn_d) |=> !miso_oe);

    // R10: while select is idle high, the frame state does not move
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (csn_s && csn_d) |=> ($stable(cnt) && $stable(sh_in)));

    // R4: commit, error and clear requests are mutually exclusive
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, err_set, stat_clr}));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_regs_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sck_i,
    input  logic                   csn_i,
    input  logic                   mosi_i,
    output logic                   miso_o,
    output logic                   miso_oe_o,
    output logic [(NREG-1)*DW-1:0] cfg_o
);
    logic [2:0]    pins_s;
    logic          sck_s, csn_s, mosi_s;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_en, err_set, stat_clr;

    spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_i, csn_i, mosi_i}),
        .q   (pins_s)
    );

    assign {sck_s, csn_s, mosi_s} = pins_s;

    spi_frame #(.DW(DW), .AW(AW)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .csn_s    (csn_s),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .err_set  (err_set),
        .stat_clr (stat_clr),
        .miso     (miso_o),
        .miso_oe  (miso_oe_o)
    );

    spi_regbank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .err_set  (err_set),
        .stat_clr (stat_clr),
        .cfg_o    (cfg_o)
    );
endmodule

// File: tb/spi_reg_port_bench.sv
module spi_reg_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int GAP        = 60;
    localparam int NR         = 16;
    localparam int DW         = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic [(NR-1)*DW-1:0] cfg;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_regs [NR];
    logic          exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_port u_spi_reg_port (
        .clk       (clk),
        .rst       (rst),
        .sck_i     (sck),
        .csn_i     (csn),
        .mosi_i    (mosi),
        .miso_o    (miso),
        .miso_oe_o (miso_oe),
        .cfg_o     (cfg)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit rd, input int addr, input logic [DW-1:0] d);
        return {rd, addr[3:0], d};
    endfunction

    function automatic logic [DW-1:0] exp_read(input int addr);
        return (addr == 0) ? DW'(exp_err) : exp_regs[addr];
    endfunction

    function automatic logic [(NR-1)*DW-1:0] exp_cfg();
        logic [(NR-1)*DW-1:0] v;
        for (int k = 1; k < NR; k++) v[(k-1)*DW +: DW] = exp_regs[k];
        return v;
    endfunction

    task automatic frame(input logic [15:0] word, input int nclk, input bit hi_start,
                         input bit hi_end, output logic [15:0] rx);
        rx = '0;
        if (hi_start) begin sck = 1'b1; wait_clk(HALF); end
        csn = 1'b0;
        wait_clk(HALF);
        chk(miso_oe === 1'b1, "R2 oe high in frame", 32'(miso_oe), 1);
        if (hi_start) begin sck = 1'b0; wait_clk(HALF); end
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 16) ? word[15-i] : 1'b0;
            sck  = 1'b1;
            wait_clk(HALF);
            if (i < 16) rx[15-i] = miso;
            sck = 1'b0;
            wait_clk(HALF);
        end
        if (hi_end) begin sck = 1'b1; wait_clk(HALF); end
        csn = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
        wait_clk(GAP);
        chk(miso_oe === 1'b0, "R2 oe low when idle", 32'(miso_oe), 0);
    endtask

    // Runs a frame, checks the response and the model, then the cfg port
    task automatic xfer(input bit rd, input int addr, input logic [DW-1:0] d, input int nclk,
                        input bit hi_start, input bit hi_end, input string req);
        logic [15:0]   rx;
        logic [DW-1:0] expv;
        bit            good;
        expv = exp_read(addr);
        frame(mk(rd, addr, d), nclk, hi_start, hi_end, rx);
        if (nclk >= 16 && !hi_start)
            chk(rx[DW-1:0] === expv, {req, " R3 response"}, 32'(rx[DW-1:0]), 32'(expv));
        good = !hi_start && !hi_end && (nclk == 16);
        if (!good)                 exp_err = 1'b1;
        else if (rd && addr == 0)  exp_err = 1'b0;
        else if (!rd && addr != 0) exp_regs[addr] = d;
        chk(cfg === exp_cfg(), {req, " R11 cfg port"}, 32'(cfg[31:0]), 32'(exp_cfg() >> 0));
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5eed_1234);
        for (int k = 0; k < NR; k++) exp_regs[k] = '0;
        exp_err = 1'b0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1 reset state
        chk(miso_oe === 1'b0, "R1 oe after reset", 32'(miso_oe), 0);
        chk(cfg === '0, "R1 cfg after reset", 32'(cfg[31:0]), 0);
        xfer(1, 0, '0, 16, 0, 0, "R1 status zero");
        xfer(1, 7, '0, 16, 0, 0, "R1 reg zero");

        // R4 R5 write returns old value
        xfer(0, 3, 11'h5A5, 16, 0, 0, "R4 write");
        xfer(1, 3, '0, 16, 0, 0, "R3 read back");
        xfer(0, 3, 11'h123, 16, 0, 0, "R5 old value");
        xfer(0, 15, 11'h7FF, 16, 0, 0, "R4 top reg");
        xfer(0, 1, 11'h001, 16, 0, 0, "R4 low reg");
        // R6 read does not modify
        xfer(1, 15, 11'h2AA, 16, 0, 0, "R6 read no change");
        xfer(1, 15, '0, 16, 0, 0, "R6 recheck");

        // R7 short and long frames
        xfer(0, 5, 11'h3C3, 10, 0, 0, "R7 short");
        xfer(1, 0, '0, 16, 0, 0, "R9 flag set");
        xfer(1, 0, '0, 16, 0, 0, "R9 flag cleared");
        xfer(0, 5, 11'h3C3, 17, 0, 0, "R7 long");
        xfer(0, 5, 11'h3C3, 15, 0, 0, "R7 fifteen");
        xfer(1, 0, '0, 16, 0, 0, "R7 flag");

        // R8 clock high at select edges
        xfer(0, 6, 11'h0F0, 16, 1, 0, "R8 high at start");
        xfer(1, 0, '0, 16, 0, 0, "R8 flag start");
        xfer(0, 6, 11'h0F0, 16, 0, 1, "R8 high at end");
        xfer(1, 0, '0, 16, 0, 0, "R8 flag end");
        xfer(1, 6, '0, 16, 0, 0, "R8 no write");

        // R9 status write ignored
        xfer(0, 0, 11'h7FF, 16, 0, 0, "R9 status write");
        xfer(1, 0, '0, 16, 0, 0, "R9 status still clear");

        // R10 activity while idle
        for (int i = 0; i < 6; i++) begin
            mosi = $urandom % 2;
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0; wait_clk(HALF);
        end
        wait_clk(GAP);
        chk(cfg === exp_cfg(), "R10 idle cfg", 32'(cfg[31:0]), 32'(exp_cfg()));
        chk(miso_oe === 1'b0, "R10 idle oe", 32'(miso_oe), 0);
        xfer(1, 0, '0, 16, 0, 0, "R10 no error");

        // Random mix
        for (int n = 0; n < 120; n++) begin
            int r, a, nc;
            r  = $urandom % 10;
            a  = $urandom % NR;
            nc = (r == 0) ? 15 : (r == 1) ? 17 : 16;
            xfer(($urandom % 2) == 1, a, DW'($urandom), nc, 0, 0, "R4 R6 R7 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule